// File: doc/BRIEF.md
# Sized Subtractor with Full Arithmetic Flags

This unit subtracts a source operand from a destination operand at one of four operand widths (8, 16, 32 or 64 bits). It returns the difference and the six arithmetic status flags that a general-purpose integer core keeps: overflow, sign, zero, nibble borrow (auxiliary carry), low-byte parity and carry. An execution stage of a processor pipeline instantiates it. The stage supplies the two register or immediate values, the operand width and a source extension mode, and it takes the merged 64-bit result for writeback.

A short immediate can arrive in the low 8 or low 32 bits of the source. The unit sign-extends it to full width before subtracting. Bits of the result above the operand width follow a fixed merge rule. A 32-bit operation clears the upper half. An 8-bit or 16-bit operation keeps the upper bits of the incoming destination value. With the default `REG_OUT = 1`, the result and the flags are registered, so they appear one clock after the inputs.

Top module: `sub_flags_unit`

## Requirements
- R1: The low W result bits equal (dst - src) mod 2^W, where W is 8, 16, 32 or 64 for size_i = 0, 1, 2 or 3.
- R2: When src_mode_i = 1, bits 63:8 of the source are replaced by copies of source bit 7 before the subtraction. When src_mode_i = 2, bits 63:32 are replaced by copies of bit 31. Modes 0 and 3 use the source as given.
- R3: cf_o is 1 exactly when the extended source, taken as an unsigned W-bit value, is greater than the W-bit destination.
- R4: of_o is 1 exactly when the W-bit operand sign bits differ and the result sign bit differs from the destination sign bit.
- R5: sf_o equals result bit W-1.
- R6: zf_o is 1 exactly when all W low result bits are zero.
- R7: af_o is 1 exactly when source bits 3:0 are greater than destination bits 3:0 as unsigned values.
- R8: pf_o is 1 exactly when result bits 7:0 hold an even number of ones, at every operand width.
- R9: For size_i = 2, result bits 63:32 are zero.
- R10: For size_i = 0 or 1, result bits above W equal the same bits of dst_i.
- R11: With REG_OUT = 1, outputs show the result of the inputs present at the previous rising clock edge. While rst_ni is low, res_o and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dst_i | input | 64 | Destination operand (minuend), also the source of preserved upper bits |
| src_i | input | 64 | Source operand (subtrahend) |
| size_i | input | 2 | Operand width: 0=8, 1=16, 2=32, 3=64 bits |
| src_mode_i | input | 2 | Source extension: 0 none, 1 from bit 7, 2 from bit 31, 3 none |
| res_o | output | 64 | Merged difference |
| of_o | output | 1 | Signed overflow |
| sf_o | output | 1 | Sign of result |
| zf_o | output | 1 | Result is zero at operand width |
| af_o | output | 1 | Borrow out of bit 3 |
| pf_o | output | 1 | Even parity of result low byte |
| cf_o | output | 1 | Unsigned borrow |

## Verification
On every cycle, the assertions check the following against the registered inputs of the previous cycle: the difference and carry when there is no extension, the overflow rule, the sign and zero flags, the low-byte parity, the nibble borrow and both upper-bit merge rules. The bench's scenarios are the only evidence for the immediate sign-extension modes and the exact flag values at width boundaries. Those boundaries include 0 - 1, the most negative value minus one and equal operands. The bench sweeps every 8-bit operand pair and uses edge-heavy operand sets at the wider sizes.

// File: rtl/sub_flags_pkg.sv
package sub_flags_pkg;
  localparam int unsigned BASE_W    = 8;
  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned DATA_W    = BASE_W << (NUM_SIZES - 1);
  localparam int unsigned SIZE_W    = $clog2(NUM_SIZES);

  typedef enum logic [1:0] {
    SRC_FULL   = 2'd0,
    SRC_SEXT8  = 2'd1,
    SRC_SEXT32 = 2'd2,
    SRC_RSVD   = 2'd3
  } src_mode_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;
endpackage

// File: rtl/src_extend.sv
module src_extend
  import sub_flags_pkg::*;
#(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] src_o
);
  always_comb begin
    unique case (src_mode_e'(mode_i))
      SRC_SEXT8:  src_o = {{(DATA_W-LO_W){src_i[LO_W-1]}}, src_i[LO_W-1:0]};
      SRC_SEXT32: src_o = {{(DATA_W-HI_W){src_i[HI_W-1]}}, src_i[HI_W-1:0]};
      default:    src_o = src_i;
    endcase
  end
endmodule

// File: rtl/sub_core.sv
module sub_core
  import sub_flags_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] diff_o,
  output flags_t            flags_o
);
  logic [DATA_W-1:0] diff_w  [NUM_SIZES];
  flags_t            flags_w [NUM_SIZES];

  // nibble borrow and parity do not depend on the width
  logic [4:0] nib;
  assign nib = {1'b0, a_i[3:0]} - {1'b0, b_i[3:0]};

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned W = BASE_W << g;
    logic [W:0]   d;
    logic [W-1:0] r;
    assign d = {1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]};
    assign r = d[W-1:0];
    assign diff_w[g] = DATA_W'(r);
    assign flags_w[g].cf = d[W];
    assign flags_w[g].sf = r[W-1];
    assign flags_w[g].zf = (r == '0);
    assign flags_w[g].of = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ r[W-1]);
    assign flags_w[g].af = nib[4];
    assign flags_w[g].pf = ~^r[7:0];
  end

  assign diff_o  = diff_w[size_i];
  assign flags_o = flags_w[size_i];
endmodule

// File: rtl/result_merge.sv
module result_merge
  import sub_flags_pkg::*;
#(
  parameter int unsigned ZEXT_FROM = 2
) (
  input  logic [DATA_W-1:0] diff_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] merged [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_merge
    localparam int unsigned W = BASE_W << g;
    if (W == DATA_W) begin : g_full
      assign merged[g] = diff_i;
    end else if (g >= ZEXT_FROM) begin : g_zext
      assign merged[g] = {{(DATA_W-W){1'b0}}, diff_i[W-1:0]};
    end else begin : g_keep
      assign merged[g] = {old_i[DATA_W-1:W], diff_i[W-1:0]};
    end
  end

  assign res_o = merged[size_i];
endmodule

// File: rtl/sub_flags_unit.sv
module sub_flags_unit
  import sub_flags_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       dst_i,
  input  logic [63:0]       src_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        src_mode_i,
  output logic [63:0]       res_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              af_o,
  output logic              pf_o,
  output logic              cf_o
);
  logic [DATA_W-1:0] src_x, diff, res_c;
  flags_t            flg_c, flg_q;
  logic [DATA_W-1:0] res_q;

  src_extend #(.LO_W(8), .HI_W(32)) u_ext (
    .src_i (src_i),
    .mode_i(src_mode_i),
    .src_o (src_x)
  );

  sub_core u_core (
    .a_i    (dst_i),
    .b_i    (src_x),
    .size_i (size_i),
    .diff_o (diff),
    .flags_o(flg_c)
  );

  result_merge #(.ZEXT_FROM(2)) u_merge (
    .diff_i(diff),
    .old_i (dst_i),
    .size_i(size_i),
    .res_o (res_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        flg_q <= '0;
      end else begin
        res_q <= res_c;
        flg_q <= flg_c;
      end
    end
  end else begin : g_comb
    assign res_q = res_c;
    assign flg_q = flg_c;
  end

  assign res_o = res_q;
  assign of_o  = flg_q.of;
  assign sf_o  = flg_q.sf;
  assign zf_o  = flg_q.zf;
  assign af_o  = flg_q.af;
  assign pf_o  = flg_q.pf;
  assign cf_o  = flg_q.cf;
endmodule

// File: rtl/sub_flags_checker.sv
module sub_flags_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] dst_i,
  input logic [63:0] src_i,
  input logic [1:0]  size_i,
  input logic [1:0]  src_mode_i,
  input logic [63:0] res_o,
  input logic        of_o,
  input logic        sf_o,
  input logic        zf_o,
  input logic        af_o,
  input logic        pf_o,
  input logic        cf_o
);
  function automatic logic [63:0] wmask(input logic [1:0] s);
    return (s == 2'd3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  function automatic logic msb(input logic [63:0] v, input logic [1:0] s);
    return v[(8 << s) - 1];
  endfunction

  if (REG_OUT) begin : g_chk
    logic seen;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen <= 1'b0;
      else         seen <= 1'b1;
    end

    AST_DIFF_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && ($past(src_mode_i) == 2'd0 || $past(src_mode_i) == 2'd3) |->
        ((res_o & wmask($past(size_i))) ==
         (($past(dst_i) - $past(src_i)) & wmask($past(size_i))))); // R1
    AST_UNSIGNED_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(src_mode_i) == 2'd0 |->
        cf_o == (($past(src_i) & wmask($past(size_i))) >
                 ($past(dst_i) & wmask($past(size_i))))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(src_mode_i) == 2'd0 |->
        of_o == ((msb($past(dst_i), $past(size_i)) != msb($past(src_i), $past(size_i))) &&
                 (msb(res_o, $past(size_i)) != msb($past(dst_i), $past(size_i))))); // R4
    AST_SIGN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> sf_o == msb(res_o, $past(size_i))); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> zf_o == ((res_o & wmask($past(size_i))) == 64'd0)); // R6
    AST_NIBBLE_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> af_o == ($past(src_i[3:0]) > $past(dst_i[3:0]))); // R7
    AST_LOW_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> pf_o == ~^res_o[7:0]); // R8
    AST_ZEXT_32: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(size_i) == 2'd2 |-> res_o[63:32] == 32'd0); // R9
    AST_KEEP_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(size_i) < 2'd2 |->
        ((res_o ^ $past(dst_i)) & ~wmask($past(size_i))) == 64'd0); // R10
  end
endmodule

bind sub_flags_unit sub_flags_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dst_i(dst_i), .src_i(src_i),
  .size_i(size_i), .src_mode_i(src_mode_i), .res_o(res_o),
  .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .af_o(af_o), .pf_o(pf_o), .cf_o(cf_o)
);

// File: tb/sub_flags_unit_tb.sv
module sub_flags_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dst = '0, src = '0;
  logic [1:0]  size = '0, mode = '0;
  logic [63:0] res;
  logic        of, sf, zf, af, pf, cf;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  sub_flags_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dst_i(dst), .src_i(src),
    .size_i(size), .src_mode_i(mode), .res_o(res),
    .of_o(of), .sf_o(sf), .zf_o(zf), .af_o(af), .pf_o(pf), .cf_o(cf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: size=%0d mode=%0d dst=%h src=%h actual=%h expected=%h",
               req, size, mode, dst, src, act, exp);
    end
  endtask

  // arithmetic reference model
  task automatic apply(input logic [63:0] d, input logic [63:0] s,
                       input logic [1:0] sz, input logic [1:0] md);
    logic [63:0] sx, m, a, b, r, full;
    int w;
    dst = d; src = s; size = sz; mode = md;
    sx = s;
    if (md == 2'd1) sx = 64'($signed(s[7:0]));
    if (md == 2'd2) sx = 64'($signed(s[31:0]));
    w = 8 << sz;
    m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    a = d & m;
    b = sx & m;
    r = (a - b) & m;
    if (sz == 2'd3)      full = r;
    else if (sz == 2'd2) full = r;
    else                 full = (d & ~m) | r;
    @(negedge clk);
    chk("R1/R2 result", res & m, r);
    chk("R9/R10 upper bits", res, full);
    chk("R3 carry", 64'(cf), 64'(b > a));
    chk("R4 overflow", 64'(of), 64'((((a ^ b) & (a ^ r)) >> (w - 1)) & 64'd1));
    chk("R5 sign", 64'(sf), (r >> (w - 1)) & 64'd1);
    chk("R6 zero", 64'(zf), 64'(r == 0));
    chk("R7 nibble borrow", 64'(af), 64'((sx & 64'hf) > (d & 64'hf)));
    chk("R8 parity", 64'(pf), 64'(($countones(r[7:0]) % 2) == 0));
  endtask

  function automatic logic [63:0] pick(input int i, input int w);
    logic [63:0] m, msbv;
    m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    msbv = 64'd1 << (w - 1);
    case (i)
      0: return 64'd0;
      1: return 64'd1;
      2: return msbv - 1;
      3: return msbv;
      4: return m;
      5: return msbv + 1;
      6: return 64'h0f;
      7: return 64'h10;
      default: return (64'h9E3779B97F4A7C15 * 64'(i)) ^ (64'hC2B2AE3D27D4EB4F >> (i % 17));
    endcase
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset result", res, 64'd0);
    chk("R11 reset flags", {58'd0, of, sf, zf, af, pf, cf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1..R8, R10: every 8-bit pair, random upper bits
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply({pick(a + 9, 64)} << 8 | 64'(a), pick(b + 300, 64) << 8 | 64'(b), 2'd0, 2'd0);
    // wider sizes: edge-heavy sets
    for (int sz = 1; sz < 4; sz++)
      for (int i = 0; i < 40; i++)
        for (int j = 0; j < 40; j++)
          apply(pick(i, 8 << sz) | (pick(i + 77, 64) & ~((sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 1))),
                pick(j, 8 << sz), 2'(sz), 2'd0);
    // R2: immediate sign extension, all sizes, modes 1..3
    for (int md = 1; md < 4; md++)
      for (int sz = 0; sz < 4; sz++)
        for (int i = 0; i < 24; i++)
          for (int j = 0; j < 12; j++)
            apply(pick(i, 64), pick(j, 8) | (pick(j + 50, 64) & ~64'hff) |
                  ((j % 2) ? 64'h80 : 64'h0) | ((j % 3 == 0) ? 64'h8000_0000 : 64'h0),
                  2'(sz), 2'(md));
    // boundary cases called out
    apply(64'd0, 64'd1, 2'd3, 2'd0);                            // R3 borrow, all ones
    apply(64'h8000_0000_0000_0000, 64'd1, 2'd3, 2'd0);          // R4 overflow
    apply(64'hFFFF_FFFF_1234_5678, 64'h1234_5678, 2'd2, 2'd0);  // R6 R9 zero and zext
    apply(64'hAAAA_AAAA_AAAA_0080, 64'hFF, 2'd0, 2'd1);         // R2 R4 imm -1
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule